// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Core

This block is the digital divider and phase-comparison logic of an integer-N frequency synthesizer. A reference divider turns the crystal reference into the comparison rate. A pulse-swallow main divider steers an external divide-by-32/33 prescaler and counts its output. A tri-state phase-frequency detector compares the two divided signals and produces pump-up and pump-down pulses for an analog charge pump. All of it runs on one sampling clock `clk`. The reference, the prescaler output and the three serial-bus lines are edge-detected against that clock. Each input must therefore stay high and low for at least one `clk` cycle.

The loop is programmed with two kinds of 20-bit serial words. One carries the reference ratio R. The other carries the swallow count A and the main count B together. The VCO-to-feedback ratio is 32·B + A. The swallow divider is a two-state machine. In SWALLOW, `mod33` is high and the prescaler divides by 33. In MAIN, `mod33` is low and it divides by 32. It moves SWALLOW→MAIN when the A-th prescaler cycle of a frame ends (transition "swallow done"). At the terminal count of B cycles it moves to SWALLOW, or to MAIN when the new A is zero (transition "frame wrap"). The detector has four states: IDLE, UP, DN and BOTH. A reference pulse moves IDLE→UP and DN→BOTH. A feedback pulse moves IDLE→DN and UP→BOTH. Coincident pulses move IDLE→BOTH. BOTH always returns to IDLE after one cycle ("clear"). A pulse that arrives while the state is BOTH is dropped.

Top module: `intn_synth_div`

## Requirements
- R1: After reset: `pump_up`, `pump_dn`, `ref_div`, `fb_div` and `prog_err` are 0. The loaded values are R=384, A=2 and B=5, so `mod33` is 1.
- R2: `ref_div` is a one-cycle pulse. It occurs once every R rising edges of `ref_in`, and the 384th edge after reset produces the first one.
- R3: `fb_div` is a one-cycle pulse. It occurs once every B rising edges of `pre_in`.
- R4: `mod33` is high during the first A prescaler cycles of each B-cycle frame and low for the rest. With a 32/33 prescaler, one `fb_div` period therefore spans 32·B + A VCO cycles.
- R5: With A=0, `mod33` stays low for the whole frame. With A=B, it stays high for the whole frame. B=1 is legal.
- R6: Serial words are 20 bits, shifted MSB first on rising `ser_clk` and transferred on the rising edge of `ser_le`. Bits [1:0] select the target. Code 00 loads R from bits [15:2]. Code 01 loads B from bits [19:7] and A from bits [6:2].
- R7: Words with select code 10 or 11 change nothing.
- R8: A word with R=0, B=0 or B<A is rejected, so the loaded values stay unchanged, and `prog_err` is set. The next accepted word clears `prog_err`.
- R9: New R, A or B values take effect only at the next terminal count of their divider, so the frame in progress completes with the old values.
- R10: A reference pulse raises `pump_up` and a feedback pulse raises `pump_dn`. The leading output holds until the lagging pulse arrives. Both outputs are then high for one cycle and both drop in the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference oscillator input |
| pre_in | input | 1 | Prescaler output (one pulse per prescaler cycle) |
| ser_clk | input | 1 | Serial bus clock |
| ser_dat | input | 1 | Serial bus data |
| ser_le | input | 1 | Serial bus latch enable |
| mod33 | output | 1 | Prescaler modulus select: 1 = divide by 33, 0 = divide by 32 |
| ref_div | output | 1 | Divided reference pulse |
| fb_div | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Charge pump source request |
| pump_dn | output | 1 | Charge pump sink request |
| prog_err | output | 1 | Last serial word was rejected as illegal |

## Verification
The bench models the prescaler arithmetically. Each cycle lasts 32 or 33 sampling clocks, chosen from `mod33` at the start of the cycle. For every B from 1 to 6 and every A from 0 to B, it checks the feedback period against 32·B + A and the number of 33-cycles per frame against A. This separates the swallow count from the main count and covers the A=0, A=B and B=1 boundaries. The reference divider is timed at ratios 384, 640, 5 and 2. The detector is driven by hand, once with the reference leading and once with the feedback leading, so that hold and clear are observed separately. Serial words with reserved selects, with B<A and with zero fields show whether programming is rejected. A reprogram in the middle of a frame shows whether the frame in progress finishes with the old ratio.

// File: rtl/intn_pkg.sv
package intn_pkg;

    // target select codes carried in the two last-shifted bits
    localparam logic [1:0] SEL_REF  = 2'b00;
    localparam logic [1:0] SEL_LOOP = 2'b01;

    typedef enum logic {
        SW_SWALLOW,
        SW_MAIN
    } sw_state_t;

    typedef enum logic [1:0] {
        PD_IDLE,
        PD_UP,
        PD_DN,
        PD_BOTH
    } pd_state_t;

endpackage

// File: rtl/intn_serial_load.sv
module intn_serial_load
    import intn_pkg::*;
#(
    parameter int R_W   = 14,
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int R_DEF = 384,
    parameter int A_DEF = 2,
    parameter int B_DEF = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_rise,
    input  logic           sdat,
    input  logic           le_rise,
    output logic [R_W-1:0] r_prog,
    output logic [A_W-1:0] a_prog,
    output logic [B_W-1:0] b_prog,
    output logic           prog_err
);

    localparam int PAY_W = (R_W > A_W + B_W) ? R_W : (A_W + B_W);
    localparam int SH_W  = PAY_W + 2;

    logic [SH_W-1:0] shreg;
    logic [1:0]      sel;
    logic [R_W-1:0]  r_new;
    logic [A_W-1:0]  a_new;
    logic [B_W-1:0]  b_new;
    logic [B_W-1:0]  a_new_ext;
    logic [B_W-1:0]  a_prog_ext;
    logic            r_ok;
    logic            ab_ok;

    always_comb begin
        sel        = shreg[1:0];
        r_new      = shreg[R_W+1:2];
        a_new      = shreg[A_W+1:2];
        b_new      = shreg[A_W+B_W+1:A_W+2];
        a_new_ext  = '0;
        a_new_ext[A_W-1:0] = a_new;
        a_prog_ext = '0;
        a_prog_ext[A_W-1:0] = a_prog;
        r_ok       = (r_new != '0);
        ab_ok      = (b_new != '0) && (b_new >= a_new_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            r_prog   <= R_W'(R_DEF);
            a_prog   <= A_W'(A_DEF);
            b_prog   <= B_W'(B_DEF);
            prog_err <= 1'b0;
        end else begin
            if (sclk_rise) begin
                shreg <= {shreg[SH_W-2:0], sdat};
            end
            if (le_rise) begin
                if (sel == SEL_REF) begin
                    if (r_ok) begin
                        r_prog   <= r_new;
                        prog_err <= 1'b0;
                    end else begin
                        prog_err <= 1'b1;
                    end
                end else if (sel == SEL_LOOP) begin
                    if (ab_ok) begin
                        a_prog   <= a_new;
                        b_prog   <= b_new;
                        prog_err <= 1'b0;
                    end else begin
                        prog_err <= 1'b1;
                    end
                end
            end
        end
    end

    // R6
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(r_prog) && $stable(a_prog) && $stable(b_prog)));

    // R8
    prog_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_prog != '0) && (b_prog != '0) && (b_prog >= a_prog_ext));

endmodule

// File: rtl/intn_ref_div.sv
module intn_ref_div #(
    parameter int R_W   = 14,
    parameter int R_DEF = 384
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_rise,
    input  logic [R_W-1:0] r_prog,
    output logic           ref_pulse
);

    logic [R_W-1:0] cnt;
    logic [R_W-1:0] r_act;
    logic           at_end;

    always_comb at_end = (cnt == r_act - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            r_act     <= R_W'(R_DEF);
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= 1'b0;
            if (ref_rise) begin
                if (at_end) begin
                    cnt       <= '0;
                    r_act     <= r_prog;   // R9: adopt at terminal count
                    ref_pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    refcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < r_act);

    // R2
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

endmodule

// File: rtl/intn_swallow_div.sv
module intn_swallow_div
    import intn_pkg::*;
#(
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int A_DEF = 2,
    parameter int B_DEF = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_rise,
    input  logic [A_W-1:0] a_prog,
    input  logic [B_W-1:0] b_prog,
    output logic           mod33,
    output logic           fb_pulse
);

    localparam logic [A_W-1:0] A_RST = A_W'(A_DEF);
    localparam logic [B_W-1:0] B_RST = B_W'(B_DEF);
    localparam sw_state_t      S_RST = (A_DEF == 0) ? SW_MAIN : SW_SWALLOW;

    sw_state_t      state, state_nx;
    logic [B_W-1:0] idx, idx_nx;
    logic [A_W-1:0] a_act, a_nx;
    logic [B_W-1:0] b_act, b_nx;
    logic [B_W-1:0] a_ext;
    logic           fb_nx;
    logic           last;

    always_comb begin
        a_ext = '0;
        a_ext[A_W-1:0] = a_act;
        last = (idx == b_act - 1'b1);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        a_nx     = a_act;
        b_nx     = b_act;
        fb_nx    = 1'b0;
        if (pre_rise) begin
            if (last) begin
                // frame wrap: adopt new values (R9)
                idx_nx   = '0;
                a_nx     = a_prog;
                b_nx     = b_prog;
                fb_nx    = 1'b1;
                state_nx = (a_prog == '0) ? SW_MAIN : SW_SWALLOW;
            end else begin
                idx_nx = idx + 1'b1;
                unique case (state)
                    SW_SWALLOW: if (idx_nx == a_ext) state_nx = SW_MAIN; // swallow done
                    SW_MAIN:    state_nx = SW_MAIN;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_RST;
            idx      <= '0;
            a_act    <= A_RST;
            b_act    <= B_RST;
            fb_pulse <= 1'b0;
        end else begin
            state    <= state_nx;
            idx      <= idx_nx;
            a_act    <= a_nx;
            b_act    <= b_nx;
            fb_pulse <= fb_nx;
        end
    end

    // outputs
    always_comb mod33 = (state == SW_SWALLOW);

    // R4
    swallow_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod33 |-> (idx < a_ext));

    // R8
    active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_act != '0) && (b_act >= a_ext));

    // R3
    fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

endmodule

// File: rtl/intn_pfd.sv
module intn_pfd
    import intn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic pump_up,
    output logic pump_dn
);

    pd_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PD_IDLE: begin
                if (ref_pulse && fb_pulse) state_nx = PD_BOTH;
                else if (ref_pulse)        state_nx = PD_UP;
                else if (fb_pulse)         state_nx = PD_DN;
            end
            PD_UP:   if (fb_pulse)  state_nx = PD_BOTH;
            PD_DN:   if (ref_pulse) state_nx = PD_BOTH;
            PD_BOTH: state_nx = PD_IDLE;   // clear
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pump_up = (state == PD_UP) || (state == PD_BOTH);
        pump_dn = (state == PD_DN) || (state == PD_BOTH);
    end

    // R10
    pfd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

    // R10
    pfd_up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && !pump_dn && !fb_pulse) |=> (pump_up && !pump_dn));

    // R10
    pfd_dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_dn && !pump_up && !ref_pulse) |=> (pump_dn && !pump_up));

endmodule

// File: rtl/intn_synth_div.sv
module intn_synth_div #(
    parameter int R_W   = 14,
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int R_DEF = 384,
    parameter int A_DEF = 2,
    parameter int B_DEF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic pre_in,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_le,
    output logic mod33,
    output logic ref_div,
    output logic fb_div,
    output logic pump_up,
    output logic pump_dn,
    output logic prog_err
);

    logic ref_q, pre_q, sclk_q, le_q;
    logic ref_rise, pre_rise, sclk_rise, le_rise;
    logic [R_W-1:0] r_prog;
    logic [A_W-1:0] a_prog;
    logic [B_W-1:0] b_prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            pre_q  <= 1'b0;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            ref_q  <= ref_in;
            pre_q  <= pre_in;
            sclk_q <= ser_clk;
            le_q   <= ser_le;
        end
    end

    always_comb begin
        ref_rise  = ref_in  & ~ref_q;
        pre_rise  = pre_in  & ~pre_q;
        sclk_rise = ser_clk & ~sclk_q;
        le_rise   = ser_le  & ~le_q;
    end

    intn_serial_load #(
        .R_W(R_W), .A_W(A_W), .B_W(B_W),
        .R_DEF(R_DEF), .A_DEF(A_DEF), .B_DEF(B_DEF)
    ) u_load (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sdat(ser_dat), .le_rise(le_rise),
        .r_prog(r_prog), .a_prog(a_prog), .b_prog(b_prog),
        .prog_err(prog_err)
    );

    intn_ref_div #(.R_W(R_W), .R_DEF(R_DEF)) u_rdiv (
        .clk(clk), .rst_n(rst_n),
        .ref_rise(ref_rise), .r_prog(r_prog), .ref_pulse(ref_div)
    );

    intn_swallow_div #(
        .A_W(A_W), .B_W(B_W), .A_DEF(A_DEF), .B_DEF(B_DEF)
    ) u_ndiv (
        .clk(clk), .rst_n(rst_n),
        .pre_rise(pre_rise), .a_prog(a_prog), .b_prog(b_prog),
        .mod33(mod33), .fb_pulse(fb_div)
    );

    intn_pfd u_pfd (
        .clk(clk), .rst_n(rst_n),
        .ref_pulse(ref_div), .fb_pulse(fb_div),
        .pump_up(pump_up), .pump_dn(pump_dn)
    );

endmodule

// File: tb/test_intn_synth_div.sv
module test_intn_synth_div;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_run = 1'b0, ref_tog = 1'b0, ref_man = 1'b0;
    logic pre_run = 1'b0, pre_mod = 1'b0, pre_man = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic ref_in, pre_in;
    logic mod33, ref_div, fb_div, pump_up, pump_dn, prog_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int cyc = 0, fb_n = 0, fb_t = 0, gap_last = 0, m33_run = 0, m33_last = 0;
    int rd_n = 0, rd_t = 0, rgap_last = 0;
    int modulus = 32, vcnt = 0;
    int le_fbn = 0;

    assign ref_in = ref_run ? ref_tog : ref_man;
    assign pre_in = pre_run ? pre_mod : pre_man;

    always #(CLK_PERIOD/2) clk = ~clk;

    intn_synth_div i_intn_synth_div (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pre_in(pre_in),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .mod33(mod33), .ref_div(ref_div), .fb_div(fb_div),
        .pump_up(pump_up), .pump_dn(pump_dn), .prog_err(prog_err)
    );

    // reference toggler, prescaler model and period monitors
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ref_run) ref_tog = ~ref_tog;
            else         ref_tog = 1'b0;
            if (fb_div) begin
                gap_last = cyc - fb_t;
                fb_t     = cyc;
                fb_n++;
                m33_last = m33_run;
                m33_run  = 0;
            end
            if (ref_div) begin
                rgap_last = cyc - rd_t;
                rd_t      = cyc;
                rd_n++;
            end
            if (pre_run) begin
                if (pre_mod) begin
                    pre_mod = 1'b0;
                    modulus = mod33 ? 33 : 32;
                    if (mod33) m33_run++;
                    vcnt = 1;
                end else begin
                    vcnt++;
                    if (vcnt >= modulus) pre_mod = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ser_send(input logic [19:0] w);
        for (int i = 19; i >= 0; i--) begin
            ser_dat = w[i];
            @(negedge clk); @(negedge clk);
            ser_clk = 1'b1;
            @(negedge clk); @(negedge clk);
            ser_clk = 1'b0;
        end
        @(negedge clk);
        le_fbn = fb_n;
        ser_le = 1'b1;
        @(negedge clk); @(negedge clk);
        ser_le = 1'b0;
        @(negedge clk);
    endtask

    task automatic ref_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ref_man = 1'b1; @(negedge clk);
            ref_man = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pre_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pre_man = 1'b1; @(negedge clk);
            pre_man = 1'b0; @(negedge clk);
        end
    endtask

    task automatic wait_fb(input int n);
        int tgt;
        tgt = fb_n + n;
        while (fb_n < tgt) @(posedge clk);
    endtask

    task automatic wait_rd(input int n);
        int tgt;
        tgt = rd_n + n;
        while (rd_n < tgt) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pump_up", pump_up, 0);
        chk("R1 pump_dn", pump_dn, 0);
        chk("R1 ref_div", ref_div, 0);
        chk("R1 fb_div", fb_div, 0);
        chk("R1 prog_err", prog_err, 0);
        chk("R1 mod33", mod33, 1);

        // R10 feedback leads; R3 default B=5
        pre_pulses(4);
        chk("R3 no fb before 5th edge", pump_dn, 0);
        pre_pulses(1);
        chk("R10 dn lead dn", pump_dn, 1);
        chk("R10 dn lead up", pump_up, 0);
        chk("R5 mod33 back high after frame", mod33, 1);
        ref_pulses(383);
        chk("R2 no ref_div before 384th edge", pump_up, 0);
        chk("R10 dn held", pump_dn, 1);
        ref_pulses(1);
        chk("R10 overlap up", pump_up, 1);
        chk("R10 overlap dn", pump_dn, 1);
        @(negedge clk);
        chk("R10 clear up", pump_up, 0);
        chk("R10 clear dn", pump_dn, 0);

        // R10 reference leads
        ref_pulses(384);
        chk("R2 up after 384 edges", pump_up, 1);
        chk("R10 up lead dn", pump_dn, 0);
        repeat (10) @(negedge clk);
        chk("R10 up held", pump_up, 1);
        pre_pulses(5);
        chk("R10 overlap2", pump_up + pump_dn, 2);
        @(negedge clk);
        chk("R10 clear2", pump_up + pump_dn, 0);

        // R4 default frame
        pre_run = 1'b1;
        wait_fb(3);
        chk("R4 default period", gap_last, 32*5 + 2);
        chk("R4 default swallow count", m33_last, 2);

        // R2 reference ratios, R6 reference word
        ref_run = 1'b1;
        wait_rd(3);
        chk("R2 ratio 384", rgap_last, 2*384);
        ser_send({4'b0, 14'd5, 2'b00});
        wait_rd(3);
        chk("R6 R2 ratio 5", rgap_last, 2*5);
        ser_send({4'b0, 14'd640, 2'b00});
        wait_rd(3);
        chk("R2 ratio 640", rgap_last, 2*640);

        // R4 R5 R6 sweep over A and B
        for (int b = 1; b <= 6; b++) begin
            for (int a = 0; a <= b; a++) begin
                logic [12:0] bv;
                logic [4:0]  av;
                bv = 13'(b);
                av = 5'(a);
                ser_send({bv, av, 2'b01});
                wait_fb(3);
                chk((a == 0 || a == b) ? "R5 period" : "R4 period", gap_last, 32*b + a);
                chk((a == 0 || a == b) ? "R5 swallow count" : "R4 swallow count", m33_last, a);
            end
        end

        // R9 frame in progress keeps the old ratio (B=6, A=6 loaded)
        ser_send({13'd3, 5'd1, 2'b01});
        while (fb_n < le_fbn + 1) @(posedge clk);
        chk("R9 old frame completes", gap_last, 32*6 + 6);
        while (fb_n < le_fbn + 2) @(posedge clk);
        chk("R9 new ratio next frame", gap_last, 32*3 + 1);

        // R7 reserved selects ignored
        ser_send({13'd1, 5'd0, 2'b10});
        wait_fb(3);
        chk("R7 select 10 ignored", gap_last, 97);
        ser_send({13'd2, 5'd0, 2'b11});
        wait_fb(3);
        chk("R7 select 11 ignored", gap_last, 97);
        chk("R7 no error flag", prog_err, 0);

        // R8 illegal words rejected
        ser_send({13'd2, 5'd4, 2'b01});
        chk("R8 B<A flagged", prog_err, 1);
        wait_fb(3);
        chk("R8 B<A kept old", gap_last, 97);
        ser_send({13'd0, 5'd0, 2'b01});
        chk("R8 B=0 flagged", prog_err, 1);
        ser_send({13'd4, 5'd3, 2'b01});
        chk("R8 flag cleared", prog_err, 0);
        wait_fb(3);
        chk("R8 valid word applied", gap_last, 32*4 + 3);
        ser_send({4'b0, 14'd0, 2'b00});
        chk("R8 R=0 flagged", prog_err, 1);
        wait_rd(3);
        chk("R8 R kept", rgap_last, 2*640);
        ser_send({4'b0, 14'd2, 2'b00});
        chk("R8 flag cleared by R word", prog_err, 0);
        wait_rd(3);
        chk("R2 ratio 2", rgap_last, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule